// File: doc/BRIEF.md
# On-Chip Data RAM Steering Controller

This block decides, for every external-data-space access issued by the CPU, whether the access is served by a 2 KB on-chip RAM placed in the top 2 KB of the 64 KB data space (F800h to FFFFh) or goes out on the external data bus. Accesses use either a full 16-bit pointer or an 8-bit register address. For the 8-bit form, the upper address byte comes from a dedicated page register that only selects the on-chip RAM when it holds F8h or more; otherwise the port-2 latch supplies the upper byte to the external bus.

A two-bit control register holds an active-low RAM enable and a bus-visibility bit. The enable is one-way: software may clear it to turn the RAM on, but only reset turns the RAM off again. The visibility bit lets the read/write strobes and address appear on the bus pins during on-chip accesses for debug. Each access spans two cycles, flagged by the CPU: in cycle 1 the address and command are presented and the decision is latched; in cycle 2 the RAM strobes or the external request are issued. The latched decision does not depend on reset, so a write that survived cycle 1 completes even if reset arrives in cycle 2, while a reset in cycle 1 drops it.

Top module: `xram_steer`

## Requirements
- R1: After reset the page register reads 00h, the control register reads 2'b01 (RAM disabled, strobes hidden), and ram_cs_o, ram_we_o, ext_req_o and bus_vis_o are 0.
- R2: For a 16-bit pointer access (acc_wide_i=1), the on-chip RAM is selected exactly when the RAM is enabled (ctrl_o[0]=0) and ptr_i >= F800h; then ram_addr_o = ptr_i[10:0]. Otherwise ext_req_o is raised.
- R3: For an 8-bit access (acc_wide_i=0), the RAM is selected exactly when the RAM is enabled and the page register >= F8h; then ram_addr_o = {page[2:0], ri_addr_i}. Otherwise ext_req_o is raised and the upper byte shown is p2_i.
- R4: A write with page_we_i or with p2_we_i loads sfr_wdata_i into the page register in the next cycle, readable on page_o.
- R5: A control write sets ctrl_o[1] to sfr_wdata_i[1]; ctrl_o[0] can be cleared by a write of 0 but a write of 1 leaves it 0; only reset returns it to 1. While ctrl_o[0]=1 every access is external.
- R6: In cycle 2, bus_vis_o is 1 for every external access and equals ctrl_o[1] (as sampled in cycle 1) for an on-chip access; addr_hi_o carries the access's upper address byte when bus_vis_o is 1 and 00h otherwise.
- R7: ram_cs_o, ram_we_o and ext_req_o are only raised in the cycle flagged by acc_c2_i immediately after the acc_c1_i cycle of the same access; they stay 0 during cycle 1.
- R8: A reset asserted during cycle 1 of an on-chip write suppresses ram_we_o in cycle 2; a reset asserted during cycle 2 does not suppress ram_we_o or change ram_addr_o.
- R9: ram_cs_o and ext_req_o are never both 1, and ram_we_o is 1 only together with ram_cs_o for a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_c1_i | input | 1 | Access cycle 1: address and command valid |
| acc_c2_i | input | 1 | Access cycle 2: strobes issued |
| acc_wide_i | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit register access |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| ptr_i | input | 16 | 16-bit pointer |
| ri_addr_i | input | 8 | 8-bit register address |
| p2_i | input | 8 | Current port-2 latch value |
| sfr_wdata_i | input | 8 | Register write data |
| page_we_i | input | 1 | Write page register |
| p2_we_i | input | 1 | Port-2 latch write (mirrored into page register) |
| ctrl_we_i | input | 1 | Write control register |
| page_o | output | 8 | Page register readback |
| ctrl_o | output | 2 | Control register readback {visible, enable_n} |
| ram_cs_o | output | 1 | On-chip RAM select |
| ram_we_o | output | 1 | On-chip RAM write enable |
| ram_addr_o | output | 11 | On-chip RAM address |
| ext_req_o | output | 1 | External bus access request |
| bus_vis_o | output | 1 | Strobes and address driven on bus pins |
| addr_hi_o | output | 8 | Upper address byte for the bus |

## Verification
The assertions watch, on every cycle, that the RAM select and the external request exclude each other, that a write enable never appears without a select, that strobes only follow a cycle-1 flag, that a cleared enable stays cleared until reset, that page writes land, and that external accesses are always visible. The exact address split, the F8h threshold across every upper byte for both access forms, the visibility combinations and the two reset-during-write cases depend on the programmed state and the reset timing, so only the bench's sweeps and directed scenarios show them.

// File: rtl/xram_pkg.sv
package xram_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned RAM_AW = 11;

  typedef struct packed {
    logic hit;
    logic ext;
    logic wr;
    logic vis;
  } acc_kind_t;
endpackage

// File: rtl/xram_sfr.sv
module xram_sfr #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] wdata_i,
  input  logic          page_we_i,
  input  logic          p2_we_i,
  input  logic          ctrl_we_i,
  output logic [PW-1:0] page_o,
  output logic          en_n_o,
  output logic          vis_o
);
  logic [PW-1:0] page_q;
  logic          en_n_q;
  logic          vis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
    end else if (page_we_i || p2_we_i) begin
      page_q <= wdata_i;
    end
  end

  // enable bit can only fall under software; reset is the only way back up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_n_q <= 1'b1;
      vis_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      en_n_q <= en_n_q & wdata_i[0];
      vis_q  <= wdata_i[1];
    end
  end

  assign page_o = page_q;
  assign en_n_o = en_n_q;
  assign vis_o  = vis_q;
endmodule

// File: rtl/xram_decode.sv
module xram_decode #(
  parameter int unsigned AW     = 16,
  parameter int unsigned RAM_AW = 11
) (
  input  logic              wide_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [7:0]        ri_i,
  input  logic [AW-9:0]     page_i,
  input  logic [AW-9:0]     p2_i,
  input  logic              en_n_i,
  output logic              hit_o,
  output logic [AW-9:0]     hi_o,
  output logic [RAM_AW-1:0] ram_addr_o
);
  localparam int unsigned PW        = AW - 8;
  localparam int unsigned PAGES     = 1 << PW;
  localparam int unsigned RAM_PAGES = 1 << (RAM_AW - 8);
  localparam logic [PW-1:0] BASE    = PW'(PAGES - RAM_PAGES);

  logic [PW-1:0] hi_sel;
  logic [7:0]    lo_sel;

  always_comb begin
    hi_sel = wide_i ? ptr_i[AW-1:8] : page_i;
    lo_sel = wide_i ? ptr_i[7:0] : ri_i;
    hit_o  = !en_n_i && (hi_sel >= BASE);
    // external 8-bit accesses take the upper byte from port 2, not the page
    if (hit_o || wide_i) hi_o = hi_sel;
    else                 hi_o = p2_i;
    ram_addr_o = {hi_sel[RAM_AW-9:0], lo_sel};
  end
endmodule

// File: rtl/xram_phase.sv
module xram_phase #(
  parameter int unsigned PW     = 8,
  parameter int unsigned RAM_AW = 11
) (
  input  logic              clk_i,
  input  logic              c1_i,
  input  logic              c2_i,
  input  logic              hit_i,
  input  logic              wr_i,
  input  logic              vis_i,
  input  logic [PW-1:0]     hi_i,
  input  logic [RAM_AW-1:0] addr_i,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ext_req_o,
  output logic              bus_vis_o,
  output logic [PW-1:0]     addr_hi_o
);
  import xram_pkg::*;

  acc_kind_t         kind_q;
  logic [PW-1:0]     hi_q;
  logic [RAM_AW-1:0] addr_q;

  // no reset: a decision latched at the end of cycle 1 must survive a cycle-2 reset;
  // during reset the enable is forced off, so nothing can be latched as a hit
  always_ff @(posedge clk_i) begin
    kind_q.hit <= c1_i & hit_i;
    kind_q.ext <= c1_i & ~hit_i;
    kind_q.wr  <= c1_i & wr_i;
    kind_q.vis <= c1_i & vis_i;
    if (c1_i) begin
      hi_q   <= hi_i;
      addr_q <= addr_i;
    end
  end

  logic vis_now;
  assign vis_now    = c2_i & (kind_q.ext | (kind_q.hit & kind_q.vis));
  assign ram_cs_o   = c2_i & kind_q.hit;
  assign ram_we_o   = c2_i & kind_q.hit & kind_q.wr;
  assign ext_req_o  = c2_i & kind_q.ext;
  assign bus_vis_o  = vis_now;
  assign ram_addr_o = addr_q;
  assign addr_hi_o  = vis_now ? hi_q : '0;
endmodule

// File: rtl/xram_steer.sv
module xram_steer #(
  parameter int unsigned AW     = xram_pkg::ADDR_W,
  parameter int unsigned RAM_AW = xram_pkg::RAM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_c1_i,
  input  logic              acc_c2_i,
  input  logic              acc_wide_i,
  input  logic              acc_wr_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [7:0]        ri_addr_i,
  input  logic [AW-9:0]     p2_i,
  input  logic [AW-9:0]     sfr_wdata_i,
  input  logic              page_we_i,
  input  logic              p2_we_i,
  input  logic              ctrl_we_i,
  output logic [AW-9:0]     page_o,
  output logic [1:0]        ctrl_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ext_req_o,
  output logic              bus_vis_o,
  output logic [AW-9:0]     addr_hi_o
);
  localparam int unsigned PW = AW - 8;

  logic [PW-1:0]     page;
  logic              en_n;
  logic              vis;
  logic              hit;
  logic [PW-1:0]     hi;
  logic [RAM_AW-1:0] addr;

  xram_sfr #(.PW(PW)) u_sfr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (sfr_wdata_i),
    .page_we_i (page_we_i),
    .p2_we_i   (p2_we_i),
    .ctrl_we_i (ctrl_we_i),
    .page_o    (page),
    .en_n_o    (en_n),
    .vis_o     (vis)
  );

  xram_decode #(.AW(AW), .RAM_AW(RAM_AW)) u_dec (
    .wide_i     (acc_wide_i),
    .ptr_i      (ptr_i),
    .ri_i       (ri_addr_i),
    .page_i     (page),
    .p2_i       (p2_i),
    .en_n_i     (en_n),
    .hit_o      (hit),
    .hi_o       (hi),
    .ram_addr_o (addr)
  );

  xram_phase #(.PW(PW), .RAM_AW(RAM_AW)) u_ph (
    .clk_i      (clk_i),
    .c1_i       (acc_c1_i),
    .c2_i       (acc_c2_i),
    .hit_i      (hit),
    .wr_i       (acc_wr_i),
    .vis_i      (vis),
    .hi_i       (hi),
    .addr_i     (addr),
    .ram_cs_o   (ram_cs_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .ext_req_o  (ext_req_o),
    .bus_vis_o  (bus_vis_o),
    .addr_hi_o  (addr_hi_o)
  );

  assign page_o = page;
  assign ctrl_o = {vis, en_n};
endmodule

// File: rtl/xram_steer_chk.sv
module xram_steer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_c1_i,
  input logic       page_we_i,
  input logic       p2_we_i,
  input logic [7:0] sfr_wdata_i,
  input logic [7:0] page_o,
  input logic [1:0] ctrl_o,
  input logic       ram_cs_o,
  input logic       ram_we_o,
  input logic       ext_req_o,
  input logic       bus_vis_o
);
  assert_cs_ext_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_cs_o && ext_req_o));

  assert_we_needs_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_cs_o);

  assert_strobe_after_c1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_cs_o || ext_req_o) |-> $past(acc_c1_i));

  assert_enable_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0] |=> !ctrl_o[0]);

  assert_disabled_no_ram_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] |-> !ram_cs_o);

  assert_page_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_we_i || p2_we_i) |=> (page_o == $past(sfr_wdata_i)));

  assert_ext_visible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> bus_vis_o);
endmodule

bind xram_steer xram_steer_chk u_chk (.*);

// File: tb/sim_xram_steer.sv
module sim_xram_steer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_c1_i = 1'b0, acc_c2_i = 1'b0, acc_wide_i = 1'b0, acc_wr_i = 1'b0;
  logic [15:0] ptr_i = '0;
  logic [7:0]  ri_addr_i = '0, p2_i = '0, sfr_wdata_i = '0;
  logic        page_we_i = 1'b0, p2_we_i = 1'b0, ctrl_we_i = 1'b0;
  logic [7:0]  page_o;
  logic [1:0]  ctrl_o;
  logic        ram_cs_o, ram_we_o, ext_req_o, bus_vis_o;
  logic [10:0] ram_addr_o;
  logic [7:0]  addr_hi_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_page = 8'h00;
  logic       m_en_n = 1'b1;
  logic       m_vis  = 1'b0;

  always #10 clk_i = ~clk_i;

  xram_steer u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk_i); ctrl_we_i = 1'b1; sfr_wdata_i = d;
    @(negedge clk_i); ctrl_we_i = 1'b0;
    m_en_n = m_en_n & d[0];
    m_vis  = d[1];
    chk("R5 ctrl readback", {30'd0, ctrl_o}, {30'd0, m_vis, m_en_n});
  endtask

  task automatic wr_page(input logic [7:0] d, input bit via_p2);
    @(negedge clk_i);
    sfr_wdata_i = d;
    if (via_p2) begin p2_we_i = 1'b1; p2_i = d; end
    else page_we_i = 1'b1;
    @(negedge clk_i); page_we_i = 1'b0; p2_we_i = 1'b0;
    m_page = d;
    chk("R4 page readback", {24'd0, page_o}, {24'd0, d});
  endtask

  task automatic access(input bit wide, input bit wr, input logic [15:0] ptr, input logic [7:0] ri);
    logic [7:0]  hs, ehi;
    logic        hit, vis;
    logic [10:0] ad;
    @(negedge clk_i);
    acc_c1_i = 1'b1; acc_c2_i = 1'b0; acc_wide_i = wide; acc_wr_i = wr;
    ptr_i = ptr; ri_addr_i = ri;
    #5;
    chk("R7 no strobe in cycle 1", {30'd0, ram_cs_o, ext_req_o}, 32'd0);
    hs  = wide ? ptr[15:8] : m_page;
    hit = !m_en_n && (hs >= 8'd248);
    ad  = {hs[2:0], wide ? ptr[7:0] : ri};
    vis = !hit || m_vis;
    ehi = hit ? hs : (wide ? ptr[15:8] : p2_i);
    @(negedge clk_i);
    acc_c1_i = 1'b0; acc_c2_i = 1'b1;
    #5;
    chk(wide ? "R2 cs" : "R3 cs", {31'd0, ram_cs_o}, {31'd0, hit});
    chk(wide ? "R2 ext" : "R3 ext", {31'd0, ext_req_o}, {31'd0, !hit});
    chk("R9 we", {31'd0, ram_we_o}, {31'd0, hit && wr});
    if (hit) chk(wide ? "R2 addr" : "R3 addr", {21'd0, ram_addr_o}, {21'd0, ad});
    chk("R6 vis", {31'd0, bus_vis_o}, {31'd0, vis});
    chk(wide ? "R6 hi byte" : "R3 hi byte", {24'd0, addr_hi_o}, {24'd0, vis ? ehi : 8'h00});
    @(negedge clk_i);
    acc_c2_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #5;
    // R1
    chk("R1 page", {24'd0, page_o}, 32'h00);
    chk("R1 ctrl", {30'd0, ctrl_o}, 32'h1);
    chk("R1 outputs", {28'd0, ram_cs_o, ram_we_o, ext_req_o, bus_vis_o}, 32'd0);

    // disabled: every access external (R5)
    for (int h = 0; h < 256; h += 8) access(1'b1, h[3], {h[7:0], 8'h5A}, 8'h00);

    wr_ctrl(8'h02);  // enable, visible
    wr_ctrl(8'h03);  // attempt to disable: ignored
    wr_ctrl(8'h01);  // hide strobes, enable stays

    for (int v = 0; v < 2; v++) begin
      wr_ctrl({6'd0, v[0], 1'b1});
      for (int h = 0; h < 256; h++) access(1'b1, h[0], {h[7:0], h[7:0] ^ 8'hA5}, 8'h00);
    end

    for (int g = 0; g < 256; g++) begin
      wr_page(g[7:0], g[0]);
      p2_i = g[7:0] ^ 8'h33;
      access(1'b0, g[1], 16'h0000, g[7:0] + 8'd7);
    end

    // R8: reset during cycle 1 of a RAM write drops it
    wr_page(8'hFD, 1'b0);
    @(negedge clk_i);
    acc_c1_i = 1'b1; acc_wide_i = 1'b1; acc_wr_i = 1'b1; ptr_i = 16'hFC21;
    #5 rst_ni = 1'b0;
    @(negedge clk_i); acc_c1_i = 1'b0; acc_c2_i = 1'b1;
    #5 chk("R8 reset in cycle 1 drops write", {31'd0, ram_we_o}, 32'd0);
    @(negedge clk_i); acc_c2_i = 1'b0; rst_ni = 1'b1;
    m_en_n = 1'b1; m_vis = 1'b0; m_page = 8'h00;
    #5;
    chk("R5 reset restores ctrl", {30'd0, ctrl_o}, 32'h1);
    chk("R1 page after reset", {24'd0, page_o}, 32'h00);

    // R8: reset during cycle 2 keeps the write
    wr_ctrl(8'h00);
    @(negedge clk_i);
    acc_c1_i = 1'b1; acc_wide_i = 1'b1; acc_wr_i = 1'b1; ptr_i = 16'hFE9C;
    @(negedge clk_i); acc_c1_i = 1'b0; acc_c2_i = 1'b1;
    rst_ni = 1'b0;
    #5;
    chk("R8 reset in cycle 2 keeps write", {31'd0, ram_we_o}, 32'd1);
    chk("R8 addr kept", {21'd0, ram_addr_o}, 32'h69C);
    @(negedge clk_i); acc_c2_i = 1'b0; rst_ni = 1'b1;
    #5 chk("R8 strobe ends", {31'd0, ram_we_o}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule